// File: doc/BRIEF.md
# Serial Input Conditioning Stage

This block prepares one serial receive line before it reaches a receive shift unit. Seven external lines and a constant high level feed a selector. The chosen line can be inverted and can pass through a two-flop synchronizer. It can also be cleaned by a majority-vote filter. The filter samples either on every clock or only when a divided-rate strobe is high. The conditioned level then goes three ways: to a status bit, to an edge detector, and to the shift unit's data and clock outputs.

The edge detector gives a trigger pulse one clock wide. It fires on rising edges, falling edges, both, or never, as the mode field sets. All settings come from a 32-bit control word that is loaded through a simple write port. The same word is read back with the live conditioned level in bit 15. The pre-processor, the clock divider and the shift unit are outside this block and connect through ports.

Top module: `sic_stage`

## Requirements
- R1: After reset the control word reads zero, `trig_o` is 0, and every bit of `ctrl_o` except bit 15 reads 0.
- R2: Control bits [2:0] select the line. Codes 0 to 6 take `ext_i[code]`. Code 7 gives a constant 1.
- R3: When control bit 8 is set, the selected line is inverted. When it is clear, the line is not changed.
- R4: When control bit 6 is set, the level passes through two clocked flops, so an input change shows on `level_o` two clocks later. When bit 6 is clear, the path adds no clock delay.
- R5: When control bit 5 is set, `level_o` takes a new value only after three samples in a row agree on it. A pulse shorter than three samples has no effect on `level_o`.
- R6: When control bit 9 is set, the filter samples only in cycles where `div_stb_i` is 1. When bit 9 is clear, it samples every clock.
- R7: Control bits [11:10] set the trigger mode: 0 is off, 1 is rising, 2 is falling, 3 is both. A matching change of `level_o` at a clock edge makes `trig_o` go high for exactly the following cycle.
- R8: `ctrl_o[15]` always equals `level_o`.
- R9: When control bit 4 is set, `shift_data_o` carries `level_o`. When it is clear, `shift_data_o` carries `pre_data_i`.
- R10: When control bit 3 is set, `shift_clk_o` carries `level_o`. When it is clear, `shift_clk_o` carries `pre_clk_i`.
- R11: Only control bits 0-6 and 8-11 can be written. Bit 7 and bits 16-31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Loads `ctrl_wdata_i` into the control word |
| ctrl_wdata_i | input | 32 | Control word write data |
| ctrl_o | output | 32 | Control word readback, with the conditioned level in bit 15 |
| ext_i | input | 7 | External candidate lines |
| div_stb_i | input | 1 | Divided-rate sampling strobe |
| pre_data_i | input | 1 | Data from the protocol pre-processor |
| pre_clk_i | input | 1 | Shift clock from the protocol pre-processor |
| level_o | output | 1 | Conditioned line level |
| trig_o | output | 1 | Edge trigger pulse |
| shift_data_o | output | 1 | Data input of the shift unit |
| shift_clk_o | output | 1 | Receive shift clock |

## Verification
The bench sends a two-sample glitch into the filter. A filter that switches on a simple majority, or on two samples, would let that glitch through. It stops the strobe for several cycles while the input changes. A filter that ignored bit 9 would follow the input too soon. It counts the synchronizer delay one clock at a time, which catches a chain with one flop too few or too many. It drives every trigger mode with both edge directions, which exposes swapped rise/fall decoding and pulses wider than one clock. Constant-one code 7, inversion, unwritable bits and both routing multiplexers are checked at the ports.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned POS_SEL    = 0;
  localparam int unsigned POS_CLKSRC = 3;
  localparam int unsigned POS_DIRECT = 4;
  localparam int unsigned POS_FILT   = 5;
  localparam int unsigned POS_SYNC   = 6;
  localparam int unsigned POS_INV    = 8;
  localparam int unsigned POS_SLOW   = 9;
  localparam int unsigned POS_MODE   = 10;
  localparam int unsigned POS_LVL    = 15;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;
endpackage

// File: rtl/sic_src_sel.sv
module sic_src_sel #(
  parameter int unsigned N_EXT = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic [N_EXT-1:0] ext_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             inv_i,
  output logic             line_o
);
  localparam int unsigned N_SLOT = 2 ** SEL_W;

  // codes past the last external line read as constant one
  logic [N_SLOT-1:0] slots;
  generate
    if (N_SLOT > N_EXT) begin : g_pad
      assign slots = {{(N_SLOT - N_EXT){1'b1}}, ext_i};
    end else begin : g_nopad
      assign slots = ext_i[N_SLOT-1:0];
    end
  endgenerate

  assign line_o = slots[sel_i] ^ inv_i;
endmodule

// File: rtl/sic_sync.sv
module sic_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d_i;
        else             chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sic_filter.sv
module sic_filter #(
  parameter int unsigned WIN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic d_i,
  output logic q_o
);
  logic [WIN-1:0] win_q;
  logic [WIN-1:0] win_nxt;

  assign win_nxt = {win_q[WIN-2:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      q_o   <= 1'b0;
    end else if (stb_i) begin
      win_q <= win_nxt;
      // output moves only on a unanimous window
      if (&win_nxt)       q_o <= 1'b1;
      else if (~|win_nxt) q_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sic_edge.sv
module sic_edge
  import sic_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  edge_mode_e mode_i,
  input  logic       d_i,
  output logic       trig_o
);
  logic prev_q;
  logic rise, fall;

  assign rise = d_i & ~prev_q;
  assign fall = ~d_i & prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      trig_o <= 1'b0;
    end else begin
      prev_q <= d_i;
      unique case (mode_i)
        EDGE_RISE: trig_o <= rise;
        EDGE_FALL: trig_o <= fall;
        EDGE_BOTH: trig_o <= rise | fall;
        default:   trig_o <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sic_stage.sv
module sic_stage
  import sic_pkg::*;
#(
  parameter int unsigned N_EXT       = 7,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_WIN    = 3,
  parameter int unsigned CTRL_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic [N_EXT-1:0]  ext_i,
  input  logic              div_stb_i,
  input  logic              pre_data_i,
  input  logic              pre_clk_i,
  output logic              level_o,
  output logic              trig_o,
  output logic              shift_data_o,
  output logic              shift_clk_o
);
  localparam logic [CTRL_W-1:0] SEL_MASK = CTRL_W'((2 ** SEL_W) - 1) << POS_SEL;
  localparam logic [CTRL_W-1:0] WR_MASK  = SEL_MASK
    | (CTRL_W'(1) << POS_CLKSRC) | (CTRL_W'(1) << POS_DIRECT)
    | (CTRL_W'(1) << POS_FILT)   | (CTRL_W'(1) << POS_SYNC)
    | (CTRL_W'(1) << POS_INV)    | (CTRL_W'(1) << POS_SLOW)
    | (CTRL_W'(3) << POS_MODE);

  logic [CTRL_W-1:0] ctrl_q;
  logic sel_line, sync_line, pre_filt, filt_line, cond, filt_stb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i & WR_MASK;
  end

  sic_src_sel #(.N_EXT(N_EXT), .SEL_W(SEL_W)) u_sel (
    .ext_i  (ext_i),
    .sel_i  (ctrl_q[POS_SEL +: SEL_W]),
    .inv_i  (ctrl_q[POS_INV]),
    .line_o (sel_line)
  );

  sic_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sel_line),
    .q_o    (sync_line)
  );

  assign pre_filt = ctrl_q[POS_SYNC] ? sync_line : sel_line;
  assign filt_stb = ctrl_q[POS_SLOW] ? div_stb_i : 1'b1;

  sic_filter #(.WIN(FILT_WIN)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (filt_stb),
    .d_i    (pre_filt),
    .q_o    (filt_line)
  );

  assign cond = ctrl_q[POS_FILT] ? filt_line : pre_filt;

  sic_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (edge_mode_e'(ctrl_q[POS_MODE +: 2])),
    .d_i    (cond),
    .trig_o (trig_o)
  );

  assign level_o      = cond;
  assign shift_data_o = ctrl_q[POS_DIRECT] ? cond : pre_data_i;
  assign shift_clk_o  = ctrl_q[POS_CLKSRC] ? cond : pre_clk_i;
  assign ctrl_o       = ctrl_q | (CTRL_W'(cond) << POS_LVL);
endmodule

// File: rtl/sic_stage_chk.sv
module sic_stage_chk #(
  parameter int unsigned CTRL_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              level_o,
  input logic              trig_o,
  input logic              shift_data_o,
  input logic              shift_clk_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (ctrl_o[14:0] == '0 && !trig_o);
    end
  end

  // R7
  trig_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctrl_o[11:10]) == 2'd0) |-> !trig_o);

  // R7
  trig_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> ($past(level_o) != $past(level_o, 2)));

  // R8
  status_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[15] == level_o);

  // R9
  direct_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[4] |-> (shift_data_o == level_o));

  // R10
  clk_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[3] |-> (shift_clk_o == level_o));

  // R11
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[7] == 1'b0) && (ctrl_o[CTRL_W-1:16] == '0));
endmodule

bind sic_stage sic_stage_chk #(.CTRL_W(CTRL_W)) u_chk (.*);

// File: tb/tb_sic_stage.sv
module tb_sic_stage;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0;
  logic [31:0] ctrl_o;
  logic [6:0]  ext_i = '0;
  logic        div_stb_i = 1'b0;
  logic        pre_data_i = 1'b0;
  logic        pre_clk_i = 1'b0;
  logic        level_o, trig_o, shift_data_o, shift_clk_o;

  always #2.5 clk_i = ~clk_i;

  sic_stage dut (.*);

  typedef struct {
    string       req;
    int          sig;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [31:0] pick(int sig);
    case (sig)
      0: return {31'd0, level_o};
      1: return {31'd0, trig_o};
      2: return {31'd0, shift_data_o};
      3: return {31'd0, shift_clk_o};
      default: return ctrl_o;
    endcase
  endfunction

  // monitor: compares pending expectations mid-cycle
  always @(negedge clk_i) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it  = q.pop_front();
      got = pick(it.sig);
      n_chk++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s sig%0d got %h exp %h", it.req, it.sig, got, it.exp);
      end
    end
  end

  task automatic chk(string req, int sig, logic [31:0] exp);
    item_t it;
    it.req = req; it.sig = sig; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wr(logic [31:0] v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    tick();
    ctrl_we_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    // R1
    chk("R1", 4, 32'h0); chk("R1", 1, 0); chk("R1", 0, 0);
    tick();

    // R2: each code picks its own line, code 7 is constant one
    for (int c = 0; c < 7; c++) begin
      wr(c);
      ext_i = 7'(1 << c);
      chk("R2", 0, 1);
      tick();
      ext_i = ~7'(1 << c);
      chk("R2", 0, 0);
      tick();
    end
    wr(7); ext_i = '0;
    chk("R2", 0, 1);
    tick();

    // R3 inversion, R8 status bit
    wr(32'h102); ext_i = '0;
    chk("R3", 0, 1); chk("R8", 4, 32'h8102);
    tick();
    ext_i = 7'h04;
    chk("R3", 0, 0); chk("R8", 4, 32'h0102);
    tick();

    // R11 reserved bits ignored
    wr(32'hFFFF_F080); ext_i = '0;
    chk("R11", 4, 32'h0);
    tick();

    // R4 two-clock synchronizer
    wr(32'h41);
    ext_i = 7'h02;
    chk("R4", 0, 0); tick();
    chk("R4", 0, 0); tick();
    chk("R4", 0, 1); tick();

    // R7 rising
    wr(32'h401);
    ext_i = '0; chk("R7", 1, 0); tick();
    chk("R7", 1, 0);
    ext_i = 7'h02; chk("R7", 1, 0); tick();
    chk("R7", 1, 1); tick();
    chk("R7", 1, 0); tick();
    // falling
    wr(32'h801);
    ext_i = '0; tick();
    chk("R7", 1, 1); tick();
    chk("R7", 1, 0);
    ext_i = 7'h02; tick();
    chk("R7", 1, 0); tick();
    // both
    wr(32'hC01);
    ext_i = '0; tick();
    chk("R7", 1, 1); tick();
    chk("R7", 1, 0);
    ext_i = 7'h02; tick();
    chk("R7", 1, 1); tick();
    // off
    wr(32'h001);
    ext_i = '0; tick();
    chk("R7", 1, 0); tick();

    // R5 majority filter at full rate
    wr(32'h21);
    ext_i = '0; tick(4);
    chk("R5", 0, 0);
    ext_i = 7'h02; chk("R5", 0, 0); tick();
    chk("R5", 0, 0); tick();
    chk("R5", 0, 0);
    ext_i = '0; tick();
    chk("R5", 0, 0); tick(2);
    chk("R5", 0, 0);
    ext_i = 7'h02; tick();
    chk("R5", 0, 0); tick();
    chk("R5", 0, 0); tick();
    chk("R5", 0, 1); tick();

    // R6 strobe-gated sampling
    wr(32'h221);
    ext_i = '0; div_stb_i = 1'b0; tick(5);
    chk("R6", 0, 1); tick();
    div_stb_i = 1'b1; tick(); div_stb_i = 1'b0;
    chk("R6", 0, 1); tick(2);
    div_stb_i = 1'b1; tick(); div_stb_i = 1'b0;
    chk("R6", 0, 1); tick();
    div_stb_i = 1'b1; tick(); div_stb_i = 1'b0;
    chk("R6", 0, 0); tick();

    // R9 data routing
    wr(32'h11);
    pre_data_i = 1'b0; ext_i = 7'h02; chk("R9", 2, 1); tick();
    ext_i = '0; pre_data_i = 1'b1; chk("R9", 2, 0); tick();
    wr(32'h01);
    ext_i = 7'h02; pre_data_i = 1'b0; chk("R9", 2, 0); tick();
    ext_i = '0; pre_data_i = 1'b1; chk("R9", 2, 1); tick();

    // R10 clock routing
    wr(32'h09);
    pre_clk_i = 1'b0; ext_i = 7'h02; chk("R10", 3, 1); tick();
    wr(32'h01);
    pre_clk_i = 1'b0; chk("R10", 3, 0); tick();
    pre_clk_i = 1'b1; ext_i = '0; chk("R10", 3, 1); tick();

    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule